// File: doc/BRIEF.md
# Cascadable dual 8-bit timer

Two independent 8-bit up-counters share one register port. Each channel picks its count source with a 3-bit select code. The choices are: stopped, one of three taps of a free-running prescaler, the other channel's event, or an external clock pin. The external pin can count on its rising edge, its falling edge or both edges. When cascaded, channel 0 advances on each wrap of channel 1, and channel 1 advances on each compare-A match of channel 0. This lets the pair form a 16-bit timer, or a counter of compare periods.

Each channel has two compare registers. A match sets a sticky flag, and each flag can raise an interrupt line. Software clears a flag with a two-step handshake. It first reads the flag while it is set, and then writes a zero to it. A zero written without that read leaves the flag in place.

Top module: `cascade_timer_pair`

## Requirements
- R1: After synchronous reset, both counters, both control registers and all flags are 0, all compare registers are 0xFF, and every interrupt output is low.
- R2: With select code 0 a counter holds its value unless software writes it.
- R3: Select codes 1, 2 and 3 advance the counter by one in each cycle where the free-running prescaler (13 bits, 0 at reset, +1 every clock) has just taken bit 2, 5 or 12 from 1 to 0. This gives one count per 8, 64 or 8192 clocks.
- R4: Channel 0 with select code 4 advances once for each wrap of channel 1 from 0xFF to 0x00, one clock after that wrap.
- R5: Channel 1 with select code 4 advances once for each compare-A match of channel 0, one clock after that match.
- R6: When both channels hold select code 4, neither channel receives any count.
- R7: Select codes 5, 6 and 7 count rising, falling or both edges of the external clock, after two synchroniser flops. There is at most one count per clock.
- R8: A compare flag (A or B) is set in the clock where the counter advances to a value equal to that compare register.
- R9: A flag is cleared only by a write with 0 in its bit, and only if the latest earlier access to that channel's status was a read that returned the flag as 1. A write of 1, or a write of 0 without that read, changes nothing.
- R10: If a match and a valid clearing write to the same flag fall in the same clock, the flag stays set.
- R11: Each interrupt output is the registered AND of its flag and its enable bit, and lags the flag by one clock.
- R12: The address layout is as follows. Bit 3 selects the channel. Bits 2:0 select the register:
  - 0 is control: bits 2:0 hold the select code, bit 3 enables interrupt A, bit 4 enables interrupt B.
  - 1 is status: bit 0 is flag A, bit 1 is flag B.
  - 2 is compare A, 3 is compare B, 4 is the counter.
  - Other offsets read 0.

  Read data is registered and appears one clock after the read strobe. A counter write takes priority over a count in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address (bit 3 = channel) |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| ext_clk | input | 1 | Asynchronous external count clock |
| irq_a | output | 2 | Compare-A interrupt per channel |
| irq_b | output | 2 | Compare-B interrupt per channel |

## Verification
A compare match that sets a flag can land in the same clock as a software write that would clear that same flag. The bench provokes this by arming the clear with a status read. It then sets the counter one below compare A and counts on the external rising edge. It times the pin edge so that the synchronised edge and the clearing write reach the same clock edge. The reference model applies set-over-clear, and the bench also expects the flag to still read as 1. The bench further judges whether a counter write arriving alongside a count wins, and whether one cascade pulse advances the other channel by exactly one.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int SEL_W = 3;
  localparam int REG_W = 3;

  localparam logic [SEL_W-1:0] SEL_OFF      = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DIV_LO   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DIV_MID  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DIV_HI   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CHAIN    = 3'd4;
  localparam logic [SEL_W-1:0] SEL_EXT_RISE = 3'd5;
  localparam logic [SEL_W-1:0] SEL_EXT_FALL = 3'd6;
  localparam logic [SEL_W-1:0] SEL_EXT_BOTH = 3'd7;

  localparam logic [REG_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [REG_W-1:0] OFS_STAT = 3'd1;
  localparam logic [REG_W-1:0] OFS_CMPA = 3'd2;
  localparam logic [REG_W-1:0] OFS_CMPB = 3'd3;
  localparam logic [REG_W-1:0] OFS_CNT  = 3'd4;
endpackage

// File: rtl/ctp_prescaler.sv
module ctp_prescaler #(
  parameter int WIDTH = 13,
  parameter int TAP_LO = 2,
  parameter int TAP_MID = 5,
  parameter int TAP_HI = 12
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] fall
);
  localparam int NTAP = 3;
  localparam int TAP [NTAP] = '{TAP_LO, TAP_MID, TAP_HI};

  logic [WIDTH-1:0] div_q;
  logic [NTAP-1:0]  prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      prev_q <= '0;
    end else begin
      div_q  <= div_q + 1'b1;
      prev_q <= {div_q[TAP_HI], div_q[TAP_MID], div_q[TAP_LO]};
    end
  end

  // one-cycle enable when a tap has just gone from 1 to 0
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign fall[i] = prev_q[i] & ~div_q[TAP[i]];
  end
endmodule

// File: rtl/ctp_edge_sync.sv
module ctp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], pin};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ctp_channel.sv
module ctp_channel
  import ctp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] reg_sel,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    rd_val,
  output logic [SEL_W-1:0] sel,
  output logic [CW-1:0]    cnt,
  output logic [CW-1:0]    cmp_a,
  output logic             flag_a,
  output logic             flag_b,
  output logic             ie_a,
  output logic             ie_b,
  output logic             ovf_pulse,
  output logic             cma_pulse,
  output logic             irq_a,
  output logic             irq_b
);
  logic [SEL_W-1:0] sel_q;
  logic             ie_a_q, ie_b_q;
  logic [CW-1:0]    cnt_q, cmp_a_q, cmp_b_q;
  logic             fa_q, fb_q, arm_a_q, arm_b_q;
  logic             ovf_q, cma_q, irq_a_q, irq_b_q;

  logic wr_ctrl, wr_stat, wr_cmpa, wr_cmpb, wr_cnt, rd_stat;
  logic advance, hit_a, hit_b;
  logic [CW-1:0] cnt_inc;

  assign wr_ctrl = wr_en && (reg_sel == OFS_CTRL);
  assign wr_stat = wr_en && (reg_sel == OFS_STAT);
  assign wr_cmpa = wr_en && (reg_sel == OFS_CMPA);
  assign wr_cmpb = wr_en && (reg_sel == OFS_CMPB);
  assign wr_cnt  = wr_en && (reg_sel == OFS_CNT);
  assign rd_stat = rd_en && (reg_sel == OFS_STAT);

  assign cnt_inc = cnt_q + 1'b1;
  assign advance = tick && !wr_cnt;
  assign hit_a   = advance && (cnt_inc == cmp_a_q);
  assign hit_b   = advance && (cnt_inc == cmp_b_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= SEL_OFF;
      ie_a_q  <= 1'b0;
      ie_b_q  <= 1'b0;
      cnt_q   <= '0;
      cmp_a_q <= '1;
      cmp_b_q <= '1;
      fa_q    <= 1'b0;
      fb_q    <= 1'b0;
      arm_a_q <= 1'b0;
      arm_b_q <= 1'b0;
      ovf_q   <= 1'b0;
      cma_q   <= 1'b0;
      irq_a_q <= 1'b0;
      irq_b_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_q  <= wdata[SEL_W-1:0];
        ie_a_q <= wdata[SEL_W];
        ie_b_q <= wdata[SEL_W+1];
      end
      if (wr_cmpa) cmp_a_q <= wdata;
      if (wr_cmpb) cmp_b_q <= wdata;

      if (wr_cnt)    cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_inc;

      ovf_q <= advance && (cnt_q == '1);
      cma_q <= hit_a;

      // a match wins over a clearing write in the same cycle
      if (hit_a)                             fa_q <= 1'b1;
      else if (wr_stat && !wdata[0] && arm_a_q) fa_q <= 1'b0;
      if (hit_b)                             fb_q <= 1'b1;
      else if (wr_stat && !wdata[1] && arm_b_q) fb_q <= 1'b0;

      if (rd_stat) begin
        arm_a_q <= fa_q;
        arm_b_q <= fb_q;
      end else if (wr_stat) begin
        arm_a_q <= 1'b0;
        arm_b_q <= 1'b0;
      end

      irq_a_q <= fa_q && ie_a_q;
      irq_b_q <= fb_q && ie_b_q;
    end
  end

  always_comb begin
    case (reg_sel)
      OFS_CTRL: rd_val = {{(CW-SEL_W-2){1'b0}}, ie_b_q, ie_a_q, sel_q};
      OFS_STAT: rd_val = {{(CW-2){1'b0}}, fb_q, fa_q};
      OFS_CMPA: rd_val = cmp_a_q;
      OFS_CMPB: rd_val = cmp_b_q;
      OFS_CNT:  rd_val = cnt_q;
      default:  rd_val = '0;
    endcase
  end

  assign sel       = sel_q;
  assign cnt       = cnt_q;
  assign cmp_a     = cmp_a_q;
  assign flag_a    = fa_q;
  assign flag_b    = fb_q;
  assign ie_a      = ie_a_q;
  assign ie_b      = ie_b_q;
  assign ovf_pulse = ovf_q;
  assign cma_pulse = cma_q;
  assign irq_a     = irq_a_q;
  assign irq_b     = irq_b_q;
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import ctp_pkg::*;
#(
  parameter int CW = 8,
  parameter int PRE_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_W:0]     addr,
  input  logic [CW-1:0]      wdata,
  input  logic               we,
  input  logic               re,
  output logic [CW-1:0]      rdata,
  input  logic               ext_clk,
  output logic [1:0]         irq_a,
  output logic [1:0]         irq_b
);
  localparam int NCH = 2;

  logic [2:0] div_fall;
  logic       ext_rise, ext_fall;
  logic       chain_ok;

  logic [NCH-1:0][CW-1:0]    cnt_v, cmpa_v, rdv_v;
  logic [NCH-1:0][SEL_W-1:0] sel_v;
  logic [NCH-1:0]            flag_a_v, flag_b_v, ie_a_v, ie_b_v;
  logic [NCH-1:0]            ovf_v, cma_v, tick_v, chain_src;
  logic [CW-1:0]             rdata_q;

  ctp_prescaler #(.WIDTH(PRE_W), .TAP_LO(2), .TAP_MID(5), .TAP_HI(PRE_W-1)) u_pre (
    .clk(clk), .rst(rst), .fall(div_fall)
  );

  ctp_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .pin(ext_clk), .rise(ext_rise), .fall(ext_fall)
  );

  // cross-channel sources: ch0 follows ch1 wrap, ch1 follows ch0 compare A
  assign chain_src[0] = ovf_v[1];
  assign chain_src[1] = cma_v[0];
  assign chain_ok     = !((sel_v[0] == SEL_CHAIN) && (sel_v[1] == SEL_CHAIN));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      case (sel_v[c])
        SEL_DIV_LO:   tick_v[c] = div_fall[0];
        SEL_DIV_MID:  tick_v[c] = div_fall[1];
        SEL_DIV_HI:   tick_v[c] = div_fall[2];
        SEL_CHAIN:    tick_v[c] = chain_ok && chain_src[c];
        SEL_EXT_RISE: tick_v[c] = ext_rise;
        SEL_EXT_FALL: tick_v[c] = ext_fall;
        SEL_EXT_BOTH: tick_v[c] = ext_rise || ext_fall;
        default:      tick_v[c] = 1'b0;
      endcase
    end

    ctp_channel #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick_v[c]),
      .wr_en    (we && (addr[REG_W] == c[0])),
      .rd_en    (re && (addr[REG_W] == c[0])),
      .reg_sel  (addr[REG_W-1:0]),
      .wdata    (wdata),
      .rd_val   (rdv_v[c]),
      .sel      (sel_v[c]),
      .cnt      (cnt_v[c]),
      .cmp_a    (cmpa_v[c]),
      .flag_a   (flag_a_v[c]),
      .flag_b   (flag_b_v[c]),
      .ie_a     (ie_a_v[c]),
      .ie_b     (ie_b_v[c]),
      .ovf_pulse(ovf_v[c]),
      .cma_pulse(cma_v[c]),
      .irq_a    (irq_a[c]),
      .irq_b    (irq_b[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= rdv_v[addr[REG_W]];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker #(
  parameter int CW = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [3:0]          addr,
  input logic [CW-1:0]       wdata,
  input logic                we,
  input logic [1:0]          irq_a,
  input logic [1:0]          irq_b,
  input logic [1:0][CW-1:0]  cnt_v,
  input logic [1:0][CW-1:0]  cmpa_v,
  input logic [1:0][2:0]     sel_v,
  input logic [1:0]          flag_a_v,
  input logic [1:0]          flag_b_v,
  input logic [1:0]          ie_a_v,
  input logic [1:0]          ie_b_v,
  input logic [1:0]          tick_v
);
  logic wr_cnt0, clr0_a;
  assign wr_cnt0 = we && (addr == 4'h4);
  assign clr0_a  = we && (addr == 4'h1) && !wdata[0];

  assert_irq_a_lags_R11: assert property (@(posedge clk) disable iff (rst)
    irq_a == $past(flag_a_v & ie_a_v));

  assert_irq_b_lags_R11: assert property (@(posedge clk) disable iff (rst)
    irq_b == $past(flag_b_v & ie_b_v));

  assert_chain_deadlock_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_v[0] == 3'd4 && sel_v[1] == 3'd4) |-> (tick_v == 2'b00));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_cnt0) |-> (cnt_v[0] == $past(cnt_v[0]) || cnt_v[0] == $past(cnt_v[0]) + 1'b1));

  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_v[0] == 3'd0 && !wr_cnt0) |=> (cnt_v[0] == $past(cnt_v[0])));

  assert_flag_set_on_match_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_a_v[0]) |-> (cnt_v[0] == $past(cmpa_v[0])));

  assert_flag_clear_by_write_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_a_v[0]) |-> $past(clr0_a));
endmodule

bind cascade_timer_pair ctp_checker #(.CW(CW)) u_ctp_checker (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
  .irq_a(irq_a), .irq_b(irq_b), .cnt_v(cnt_v), .cmpa_v(cmpa_v),
  .sel_v(sel_v), .flag_a_v(flag_a_v), .flag_b_v(flag_b_v),
  .ie_a_v(ie_a_v), .ie_b_v(ie_b_v), .tick_v(tick_v)
);

// File: tb/cascade_timer_pair_bench.sv
module cascade_timer_pair_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic       ext_clk = 1'b0;
  logic [7:0] rdata;
  logic [1:0] irq_a, irq_b;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  cascade_timer_pair u_cascade_timer_pair (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .ext_clk(ext_clk), .irq_a(irq_a), .irq_b(irq_b)
  );

  // ---------------- behavioural reference model ----------------
  int m_pre;
  int m_prev [3];
  int m_s1, m_s2, m_s3;
  int m_sel [2], m_iea [2], m_ieb [2];
  int m_cnt [2], m_cmpa [2], m_cmpb [2];
  int m_fa [2], m_fb [2], m_arma [2], m_armb [2];
  int m_ovf [2], m_mpa [2], m_irqa [2], m_irqb [2];
  int m_rd;

  always @(posedge clk) begin : model
    int taps [3];
    int fl [3];
    int t [2];
    int n_cnt [2], n_ovf [2], n_mpa [2], n_fa [2], n_fb [2];
    int n_arma [2], n_armb [2], n_irqa [2], n_irqb [2];
    int xr, xf, both, ch, rg, ma, mb, wr;
    if (rst) begin
      m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rd = 0;
      for (int k = 0; k < 3; k++) m_prev[k] = 0;
      for (int c = 0; c < 2; c++) begin
        m_sel[c] = 0; m_iea[c] = 0; m_ieb[c] = 0; m_cnt[c] = 0;
        m_cmpa[c] = 255; m_cmpb[c] = 255; m_fa[c] = 0; m_fb[c] = 0;
        m_arma[c] = 0; m_armb[c] = 0; m_ovf[c] = 0; m_mpa[c] = 0;
        m_irqa[c] = 0; m_irqb[c] = 0;
      end
    end else begin
      taps[0] = 2; taps[1] = 5; taps[2] = 12;
      for (int k = 0; k < 3; k++) fl[k] = (m_prev[k] == 1 && ((m_pre >> taps[k]) & 1) == 0) ? 1 : 0;
      xr = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      xf = (m_s2 == 0 && m_s3 == 1) ? 1 : 0;
      both = (m_sel[0] == 4 && m_sel[1] == 4) ? 1 : 0;
      ch = int'(addr[3]);
      rg = int'(addr[2:0]);
      for (int c = 0; c < 2; c++) begin
        case (m_sel[c])
          1: t[c] = fl[0];
          2: t[c] = fl[1];
          3: t[c] = fl[2];
          4: t[c] = both ? 0 : (c == 0 ? m_ovf[1] : m_mpa[0]);
          5: t[c] = xr;
          6: t[c] = xf;
          7: t[c] = (xr || xf) ? 1 : 0;
          default: t[c] = 0;
        endcase
        wr = (we && ch == c) ? 1 : 0;
        n_cnt[c] = m_cnt[c]; n_ovf[c] = 0; ma = 0; mb = 0;
        if (wr && rg == 4) n_cnt[c] = int'(wdata);
        else if (t[c]) begin
          n_cnt[c] = (m_cnt[c] + 1) % 256;
          n_ovf[c] = (m_cnt[c] == 255) ? 1 : 0;
          ma = (n_cnt[c] == m_cmpa[c]) ? 1 : 0;
          mb = (n_cnt[c] == m_cmpb[c]) ? 1 : 0;
        end
        n_mpa[c] = ma;
        n_fa[c] = ma ? 1 : ((wr && rg == 1 && !wdata[0] && m_arma[c]) ? 0 : m_fa[c]);
        n_fb[c] = mb ? 1 : ((wr && rg == 1 && !wdata[1] && m_armb[c]) ? 0 : m_fb[c]);
        n_arma[c] = m_arma[c]; n_armb[c] = m_armb[c];
        if (wr && rg == 1) begin n_arma[c] = 0; n_armb[c] = 0; end
        if (re && ch == c && rg == 1) begin n_arma[c] = m_fa[c]; n_armb[c] = m_fb[c]; end
        n_irqa[c] = (m_fa[c] && m_iea[c]) ? 1 : 0;
        n_irqb[c] = (m_fb[c] && m_ieb[c]) ? 1 : 0;
      end
      if (re) begin
        case (rg)
          0: m_rd = m_sel[ch] + 8 * m_iea[ch] + 16 * m_ieb[ch];
          1: m_rd = m_fa[ch] + 2 * m_fb[ch];
          2: m_rd = m_cmpa[ch];
          3: m_rd = m_cmpb[ch];
          4: m_rd = m_cnt[ch];
          default: m_rd = 0;
        endcase
      end
      for (int c = 0; c < 2; c++) begin
        if (we && ch == c) begin
          if (rg == 0) begin
            m_sel[c] = int'(wdata[2:0]); m_iea[c] = int'(wdata[3]); m_ieb[c] = int'(wdata[4]);
          end
          if (rg == 2) m_cmpa[c] = int'(wdata);
          if (rg == 3) m_cmpb[c] = int'(wdata);
        end
        m_cnt[c] = n_cnt[c]; m_ovf[c] = n_ovf[c]; m_mpa[c] = n_mpa[c];
        m_fa[c] = n_fa[c]; m_fb[c] = n_fb[c]; m_arma[c] = n_arma[c]; m_armb[c] = n_armb[c];
        m_irqa[c] = n_irqa[c]; m_irqb[c] = n_irqb[c];
      end
      for (int k = 0; k < 3; k++) m_prev[k] = (m_pre >> taps[k]) & 1;
      m_pre = (m_pre + 1) % 8192;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_clk);
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      check("R11 irq_a per cycle", int'(irq_a), m_irqa[0] + 2 * m_irqa[1]);
      check("R11 irq_b per cycle", int'(irq_b), m_irqb[0] + 2 * m_irqb[1]);
      check("R12 rdata per cycle", int'(rdata), m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = a[3:0]; wdata = d[7:0]; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, input string tag, output int v);
    @(negedge clk);
    addr = a[3:0]; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    v = int'(rdata);
    check(tag, v, m_rd);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1; idle(4);
      @(negedge clk); ext_clk = 1'b0; idle(4);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R1: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : stim
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;

    // R1: reset values
    rd(4'h0, "R1 ctrl0", v);  check("R1 ctrl0 value", v, 0);
    rd(4'h9, "R1 stat1", v);  check("R1 stat1 value", v, 0);
    rd(4'h2, "R1 cmpa0", v);  check("R1 cmpa0 value", v, 255);
    rd(4'hB, "R1 cmpb1", v);  check("R1 cmpb1 value", v, 255);
    check("R1 irq low", int'({irq_a, irq_b}), 0);
    rd(4'h5, "R12 unused", v); check("R12 unused offset reads 0", v, 0);

    // R2: stopped counter holds
    idle(50);
    rd(4'h4, "R2 cnt0", v);   check("R2 cnt0 unchanged", v, 0);

    // R3: prescaler taps
    wr(4'h0, 1); wr(4'h8, 2);
    idle(100);
    rd(4'h4, "R3 div8 cnt0", v);
    rd(4'hC, "R3 div64 cnt1", v);
    wr(4'h0, 3); wr(4'h4, 0);
    idle(16400);
    rd(4'h4, "R3 div8192 cnt0", v);

    // R4: ch0 counts wraps of ch1
    wr(4'h0, 4); wr(4'h8, 1); wr(4'hC, 8'hF0); wr(4'h4, 0);
    idle(200);
    rd(4'h4, "R4 cascade cnt0", v); check("R4 one wrap", v, 1);

    // R5: ch1 counts ch0 compare-A matches
    wr(4'h0, 1); wr(4'h8, 4); wr(4'h2, 5); wr(4'h4, 0); wr(4'hC, 0);
    idle(60);
    rd(4'hC, "R5 cascade cnt1", v); check("R5 one match", v, 1);

    // R6: both channels chained -> no counting
    wr(4'h0, 4); wr(4'h8, 4); wr(4'h4, 8'h10); wr(4'hC, 8'h20);
    idle(300);
    rd(4'h4, "R6 cnt0", v); check("R6 cnt0 frozen", v, 16);
    rd(4'hC, "R6 cnt1", v); check("R6 cnt1 frozen", v, 32);

    // R7: external edges
    wr(4'h0, 5); wr(4'h8, 7); wr(4'h4, 0); wr(4'hC, 0);
    ext_pulses(5); idle(4);
    rd(4'h4, "R7 rise cnt0", v); check("R7 rising edges", v, 5);
    rd(4'hC, "R7 both cnt1", v); check("R7 both edges", v, 10);
    wr(4'h0, 6); wr(4'h4, 0);
    ext_pulses(3); idle(4);
    rd(4'h4, "R7 fall cnt0", v); check("R7 falling edges", v, 3);

    // R8: compare flags set by matches
    wr(4'h0, 0); wr(4'h2, 2); wr(4'h3, 3); wr(4'h4, 0); wr(4'h0, 1);
    idle(60);
    wr(4'h0, 8'h18);
    idle(3);
    check("R11 irq_a0 high", int'(irq_a[0]), 1);
    check("R11 irq_b0 high", int'(irq_b[0]), 1);

    // R9: clear handshake
    wr(4'h1, 3);
    wr(4'h1, 0);
    rd(4'h1, "R9 stat no clear", v); check("R9 write without read keeps flags", v, 3);
    wr(4'h1, 0);
    rd(4'h1, "R9 stat cleared", v);  check("R9 read then write 0 clears", v, 0);
    idle(3);
    check("R11 irq_a0 low", int'(irq_a[0]), 0);

    // R10: set and clear in the same cycle
    wr(4'h0, 5); wr(4'h4, 1);
    ext_pulses(1); idle(4);
    rd(4'h1, "R8 stat after ext match", v); check("R8 flag A set", v & 1, 1);
    wr(4'h4, 1);
    rd(4'h1, "R10 arm read", v);
    @(negedge clk); ext_clk = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 4'h1; wdata = 8'h00; we = 1'b1;
    @(negedge clk); we = 1'b0;
    idle(2);
    rd(4'h4, "R10 counter advanced", v); check("R10 counter reached compare", v, 2);
    rd(4'h1, "R10 stat", v); check("R10 set wins over clear", v & 1, 1);

    // R12: counter write wins over a count in the same clock
    wr(4'h0, 7);
    @(negedge clk); ext_clk = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = 4'h4; wdata = 8'h40; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(4'h4, "R12 write priority", v); check("R12 write beats count", v, 64);

    idle(5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule